// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A bus-attached peripheral that gives a processor 24 general-purpose I/O lines: two 8-bit ports (A and B) and a third port (C) handled as two 4-bit halves. Port A and the upper half of port C form one group, port B and the lower half of port C form the other. Each of the four sections (A, B, C-upper, C-lower) is set to input or output by a setup word written to the control address. An output section drives its latched value on its lines. An input section presents the line values when the processor reads it.

The processor side is an 8-bit data bus split into `data_i`, `data_o` and `data_oe_o`, with active-low chip select, read and write strobes and a two-bit register address. Strobes are sampled on the rising clock edge, so a write takes effect on the edge where it is seen. A read is combinational for as long as the read condition holds.

The control address takes two kinds of word, selected by bit 7. With bit 7 set the word configures direction. With bit 7 clear it sets or clears one chosen port C latch bit. Only the plain latched and buffered I/O mode is provided.

Top module: `ppi_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every output enable is low, every output latch is zero, and a read of address 3 returns 0x9B.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control word. A write cycle (`cs_ni`=0, `wr_ni`=0, `rd_ni`=1) to address 0, 1 or 2 loads `data_i` into that port's output latch, which is seen on `pa_o`, `pb_o` or `pc_o` after the edge.
- R3: `data_oe_o` is high only during a read cycle (`cs_ni`=0, `rd_ni`=0, `wr_ni`=1). Otherwise the bus is released and `data_o` is zero.
- R4: A control write with bit 7 = 1 sets the directions: bit 4 = 1 makes port A input, bit 3 = 1 makes port C bits 7..4 input, bit 1 = 1 makes port B input and bit 0 = 1 makes port C bits 3..0 input. The output enables of every line in a section follow from the edge that takes the word.
- R5: Any control write with bit 7 = 1 clears all three output latches to zero.
- R6: A control write with bit 7 = 0 is a single-bit command. Bits 3..1 select port C bit 0..7 and bit 0 is the new value (1 sets, 0 clears). Bits 6..4 are ignored. No other latch bit and no direction changes.
- R7: A read of a port returns, per line, the line input when that line's section is input and the output latch when it is output. For port C this holds per half.
- R8: Bits 6, 5 and 2 of a setup word are ignored. A read of address 3 returns {1, 0, 0, A-in, Cupper-in, 0, B-in, Clower-in}.
- R9: A cycle with `cs_ni` high, or with `rd_ni` and `wr_ni` both low, writes nothing and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| data_oe_o | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A line inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A line enables |
| pb_i | input | 8 | Port B line inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B line enables |
| pc_i | input | 8 | Port C line inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C line enables |

## Verification
The bench builds the block with its default 8-bit data width. The control-word bit positions depend on that width, so this is the only width at which the setup and single-bit formats can be exercised. At this width all eight port C bit selects are reachable, along with every mix of input and output sections, including port C halves that point in opposite directions. It also covers strobe conflicts in which read and write are both low.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_PA  = 2'd0,
    SEL_PB  = 2'd1,
    SEL_PC  = 2'd2,
    SEL_CTL = 2'd3
  } ppi_sel_e;

  typedef struct packed {
    logic a_in;
    logic chi_in;
    logic b_in;
    logic clo_in;
  } ppi_dir_t;

  localparam ppi_dir_t DIR_RESET = '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};
endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] addr_i,
  output logic       rd_en_o,
  output logic       wr_pa_o,
  output logic       wr_pb_o,
  output logic       wr_pc_o,
  output logic       wr_ctl_o
);
  logic wr_en;

  assign rd_en_o = ~cs_ni & ~rd_ni & wr_ni;
  assign wr_en   = ~cs_ni & ~wr_ni & rd_ni;

  always_comb begin
    wr_pa_o  = 1'b0;
    wr_pb_o  = 1'b0;
    wr_pc_o  = 1'b0;
    wr_ctl_o = 1'b0;
    if (wr_en) begin
      unique case (ppi_sel_e'(addr_i))
        SEL_PA:  wr_pa_o  = 1'b1;
        SEL_PB:  wr_pb_o  = 1'b1;
        SEL_PC:  wr_pc_o  = 1'b1;
        SEL_CTL: wr_ctl_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output ppi_dir_t          dir_o,
  output logic              setup_o,
  output logic [DATA_W-1:0] bit_en_o,
  output logic              bit_val_o,
  output logic [DATA_W-1:0] cw_rd_o
);
  localparam int unsigned SEL_W = $clog2(DATA_W);

  ppi_dir_t           dir_q;
  logic               bsr;
  logic [SEL_W-1:0]   bit_sel;

  assign setup_o   = wr_ctl_i & data_i[DATA_W-1];
  assign bsr       = wr_ctl_i & ~data_i[DATA_W-1];
  assign bit_sel   = data_i[SEL_W:1];
  assign bit_val_o = data_i[0];

  always_comb begin
    bit_en_o = '0;
    if (bsr) bit_en_o[bit_sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RESET;
    end else if (setup_o) begin
      // mode bits 6,5,2 are not decoded
      dir_q.a_in   <= data_i[4];
      dir_q.chi_in <= data_i[3];
      dir_q.b_in   <= data_i[1];
      dir_q.clo_in <= data_i[0];
    end
  end

  assign dir_o = dir_q;

  always_comb begin
    cw_rd_o     = '0;
    cw_rd_o[7]  = 1'b1;
    cw_rd_o[4]  = dir_q.a_in;
    cw_rd_o[3]  = dir_q.chi_in;
    cw_rd_o[1]  = dir_q.b_in;
    cw_rd_o[0]  = dir_q.clo_in;
  end
endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] bit_en_i,
  input  logic             bit_val_i,
  input  logic             is_in_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] rd_o
);
  logic [WIDTH-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (clr_i) begin
      latch_q <= '0;
    end else if (wr_i) begin
      latch_q <= wr_data_i;
    end else begin
      for (int i = 0; i < WIDTH; i++) begin
        if (bit_en_i[i]) latch_q[i] <= bit_val_i;
      end
    end
  end

  assign out_o = latch_q;
  assign oe_o  = {WIDTH{~is_in_i}};
  assign rd_o  = is_in_i ? pin_i : latch_q;
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe_o,
  input  logic [DATA_W-1:0] pb_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe_o,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] pc_oe_o
);
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned N_HALF = 2;

  logic              rd_en, wr_pa, wr_pb, wr_pc, wr_ctl;
  ppi_dir_t          dir;
  logic              setup;
  logic [DATA_W-1:0] bit_en;
  logic              bit_val;
  logic [DATA_W-1:0] cw_rd, pa_rd, pb_rd, pc_rd;
  logic [N_HALF-1:0] c_in;

  ppi_bus_decode u_dec (
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .addr_i   (addr_i),
    .rd_en_o  (rd_en),
    .wr_pa_o  (wr_pa),
    .wr_pb_o  (wr_pb),
    .wr_pc_o  (wr_pc),
    .wr_ctl_o (wr_ctl)
  );

  ppi_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctl_i  (wr_ctl),
    .data_i    (data_i),
    .dir_o     (dir),
    .setup_o   (setup),
    .bit_en_o  (bit_en),
    .bit_val_o (bit_val),
    .cw_rd_o   (cw_rd)
  );

  ppi_port #(.WIDTH(DATA_W)) u_pa (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (setup),
    .wr_i      (wr_pa),
    .wr_data_i (data_i),
    .bit_en_i  ('0),
    .bit_val_i (1'b0),
    .is_in_i   (dir.a_in),
    .pin_i     (pa_i),
    .out_o     (pa_o),
    .oe_o      (pa_oe_o),
    .rd_o      (pa_rd)
  );

  ppi_port #(.WIDTH(DATA_W)) u_pb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (setup),
    .wr_i      (wr_pb),
    .wr_data_i (data_i),
    .bit_en_i  ('0),
    .bit_val_i (1'b0),
    .is_in_i   (dir.b_in),
    .pin_i     (pb_i),
    .out_o     (pb_o),
    .oe_o      (pb_oe_o),
    .rd_o      (pb_rd)
  );

  // port C: lower half belongs to group B, upper half to group A
  assign c_in = {dir.chi_in, dir.clo_in};

  for (genvar h = 0; h < N_HALF; h++) begin : g_pc
    ppi_port #(.WIDTH(NIB_W)) u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (setup),
      .wr_i      (wr_pc),
      .wr_data_i (data_i[h*NIB_W +: NIB_W]),
      .bit_en_i  (bit_en[h*NIB_W +: NIB_W]),
      .bit_val_i (bit_val),
      .is_in_i   (c_in[h]),
      .pin_i     (pc_i[h*NIB_W +: NIB_W]),
      .out_o     (pc_o[h*NIB_W +: NIB_W]),
      .oe_o      (pc_oe_o[h*NIB_W +: NIB_W]),
      .rd_o      (pc_rd[h*NIB_W +: NIB_W])
    );
  end

  always_comb begin
    data_o = '0;
    if (rd_en) begin
      unique case (ppi_sel_e'(addr_i))
        SEL_PA:  data_o = pa_rd;
        SEL_PB:  data_o = pb_rd;
        SEL_PC:  data_o = pc_rd;
        SEL_CTL: data_o = cw_rd;
        default: data_o = '0;
      endcase
    end
  end

  assign data_oe_o = rd_en;
endmodule

// File: rtl/ppi_chk.sv
module ppi_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] pa_o,
  input logic [DATA_W-1:0] pa_oe_o,
  input logic [DATA_W-1:0] pb_o,
  input logic [DATA_W-1:0] pb_oe_o,
  input logic [DATA_W-1:0] pc_o,
  input logic [DATA_W-1:0] pc_oe_o
);
  logic wr_cyc, setup_w, bsr_w;
  assign wr_cyc  = ~cs_ni & ~wr_ni & rd_ni;
  assign setup_w = wr_cyc & (addr_i == 2'd3) & data_i[DATA_W-1];
  assign bsr_w   = wr_cyc & (addr_i == 2'd3) & ~data_i[DATA_W-1];

  AST_BUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni | rd_ni | ~wr_ni) |-> (!data_oe_o && data_o == '0)); // R3

  AST_SETUP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_w |=> (pa_o == '0 && pb_o == '0 && pc_o == '0)); // R5

  AST_BSR_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_w |=> ($countones(pc_o ^ $past(pc_o)) <= 1 && $stable(pa_o) && $stable(pb_o))); // R6

  AST_BSR_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_w |=> ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o))); // R6

  AST_DIR_ONLY_BY_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pa_oe_o, pb_oe_o, pc_oe_o}) |-> $past(setup_w)); // R4

  AST_PA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && addr_i == 2'd0) |=> (pa_o == $past(data_i))); // R2

  AST_NO_WRITE_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && !wr_ni) |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o))); // R9
endmodule

bind ppi_top ppi_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .wr_ni     (wr_ni),
  .addr_i    (addr_i),
  .data_i    (data_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .pa_o      (pa_o),
  .pa_oe_o   (pa_oe_o),
  .pb_o      (pb_o),
  .pb_oe_o   (pb_oe_o),
  .pc_o      (pc_o),
  .pc_oe_o   (pc_oe_o)
);

// File: tb/ppi_top_tb_top.sv
module ppi_top_tb_top;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic [DW-1:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [DW-1:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] rv;

  always #2 clk_i = ~clk_i;

  ppi_top #(.DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    cs_ni = 1'b0; wr_ni = 1'b0; rd_ni = 1'b1; addr_i = a; data_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; wr_ni = 1'b1; addr_i = a;
    #1;
    d = data_o;
    chk("R3 read drives bus", 32'(data_oe_o), 32'd1);
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 pa_oe", 32'(pa_oe_o), 0);
    chk("R1 pb_oe", 32'(pb_oe_o), 0);
    chk("R1 pc_oe", 32'(pc_oe_o), 0);
    chk("R1 latches", {8'h0, pa_o, pb_o, pc_o}, 0);
    chk("R3 idle released", 32'(data_oe_o), 0);
    bus_rd(2'd3, rv);
    chk("R1 control readback", 32'(rv), 32'h9B);
  endtask

  task automatic t_all_out;
    bus_wr(2'd3, 8'h80);
    chk("R4 pa_oe all out", 32'(pa_oe_o), 32'hFF);
    chk("R4 pb_oe all out", 32'(pb_oe_o), 32'hFF);
    chk("R4 pc_oe all out", 32'(pc_oe_o), 32'hFF);
    pa_i = 8'h11; pb_i = 8'h22; pc_i = 8'h33;
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    chk("R2 port A latch", 32'(pa_o), 32'h5A);
    chk("R2 port B latch", 32'(pb_o), 32'hC3);
    chk("R2 port C latch", 32'(pc_o), 32'h96);
    bus_rd(2'd0, rv); chk("R7 read output A", 32'(rv), 32'h5A);
    bus_rd(2'd1, rv); chk("R7 read output B", 32'(rv), 32'hC3);
    bus_rd(2'd3, rv); chk("R8 readback all out", 32'(rv), 32'h80);
  endtask

  task automatic t_mixed;
    bus_wr(2'd3, 8'h91); // A in, Cupper out, B out, Clower in
    chk("R5 A cleared", 32'(pa_o), 0);
    chk("R5 B cleared", 32'(pb_o), 0);
    chk("R5 C cleared", 32'(pc_o), 0);
    chk("R4 pa_oe in", 32'(pa_oe_o), 0);
    chk("R4 pb_oe out", 32'(pb_oe_o), 32'hFF);
    chk("R4 pc_oe split", 32'(pc_oe_o), 32'hF0);
    pa_i = 8'h3C; pc_i = 8'hA5;
    bus_wr(2'd2, 8'h7E);
    chk("R2 C latch under split", 32'(pc_o), 32'h7E);
    bus_rd(2'd0, rv); chk("R7 read input A", 32'(rv), 32'h3C);
    bus_rd(2'd2, rv); chk("R7 read split C", 32'(rv), 32'h75);
    bus_rd(2'd3, rv); chk("R8 readback mixed", 32'(rv), 32'h91);
  endtask

  task automatic t_mode_ignored;
    bus_wr(2'd3, 8'hE4);
    chk("R8 mode bits ignored pa_oe", 32'(pa_oe_o), 32'hFF);
    chk("R8 mode bits ignored pc_oe", 32'(pc_oe_o), 32'hFF);
    bus_rd(2'd3, rv); chk("R8 readback drops mode bits", 32'(rv), 32'h80);
  endtask

  task automatic t_bsr;
    bus_wr(2'd0, 8'h44);
    bus_wr(2'd3, 8'h0F); chk("R6 set bit7", 32'(pc_o), 32'h80);
    bus_wr(2'd3, 8'h07); chk("R6 set bit3", 32'(pc_o), 32'h88);
    bus_wr(2'd3, 8'h0E); chk("R6 clear bit7", 32'(pc_o), 32'h08);
    bus_wr(2'd3, 8'h71); chk("R6 set bit0 dont-care", 32'(pc_o), 32'h09);
    bus_wr(2'd3, 8'h06); chk("R6 clear bit3", 32'(pc_o), 32'h01);
    chk("R6 port A untouched", 32'(pa_o), 32'h44);
    chk("R6 directions kept", {8'h0, pa_oe_o, pb_oe_o, pc_oe_o}, 32'hFFFFFF);
    bus_rd(2'd3, rv); chk("R6 control word kept", 32'(rv), 32'h80);
  endtask

  task automatic t_conflict;
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; wr_ni = 1'b0; addr_i = 2'd0; data_i = 8'hFF;
    #1;
    chk("R9 both strobes no drive", 32'(data_oe_o), 0);
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1; wr_ni = 1'b1;
    chk("R9 both strobes no write", 32'(pa_o), 32'h44);
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b0; addr_i = 2'd1; data_i = 8'hAA;
    #1;
    chk("R3 deselected no drive", 32'(data_oe_o), 0);
    @(negedge clk_i);
    wr_ni = 1'b1;
    chk("R9 deselected no write", 32'(pb_o), 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 during reset", {8'h0, pa_oe_o, pb_oe_o, pc_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_all_out();
    t_mixed();
    t_mode_ignored();
    t_bsr();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule